// File: doc/BRIEF.md
# GPIO Interrupt and Alternate-Function Controller

The controller manages 24 general-purpose pins, organised as three banks of eight. Every pin has an output data bit, a direction bit and an alternate-function select bit. When the alternate function is selected, the pin's output enable is withdrawn so that a peripheral can take over the pad. Software reaches everything through a byte-wide register bus. The bus has a write strobe and a combinational read port. The output data is written through an address-masked window, so one pin can be set or cleared without a read-modify-write.

Bank 0 also detects interrupts. Each of its eight pins is synchronised by two flops. Software then chooses one of five conditions for the pin: level high, level low, rising edge, falling edge, or both edges. Edge events are latched until software clears them. Level conditions follow the pin directly. Raw status and masked status (raw AND enable) can both be read. Four interrupt lines go to a parent interrupt controller. Pins 0, 1 and 2 each own one line, and pins 3 to 7 share the fourth. The bus carries no streaming data, so it has no valid/ready handshake. A write completes on the clock edge at which `bus_we` is high, and read data is valid in the same cycle as the address.

Address layout: `bus_addr[11:10]` selects the region (0 = data window, 1 = control). `bus_addr[9:8]` selects the bank. In the data window, `bus_addr[7:0]` is the bit mask. In the control region, `bus_addr[3:0]` indexes a register: 0 direction, 1 alternate select, 2 level-mode, 3 both-edges, 4 polarity, 5 enable, 6 raw status (read-only), 7 masked status (read-only), 8 clear (write-only, reads 0).

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, `gpio_out`, `gpio_oe`, `alt_sel` and `irq_o` are all zero, and every control register reads zero.
- R2: A write to the data window of bank b with mask m changes only the output bits whose mask bit is 1. The new value of those bits is taken from `bus_wdata`.
- R3: Pin b*8+n drives `gpio_oe` high only when its direction bit (index 0, bit n) is 1 and its alternate select bit (index 1, bit n) is 0. `alt_sel[b*8+n]` equals the alternate select bit n of bank b.
- R4: A data-window read returns, ANDed with the mask, the driven output value for output pins and the synchronised input value for input pins. The input value appears two clocks after the pin changes.
- R5: In level mode (index 2 bit = 1), raw status equals the synchronised input when the polarity bit (index 4) is 1, and its inverse when that bit is 0. A clear write does not change it.
- R6: In edge mode with both-edges (index 3) bit 0, polarity 1 latches only rising edges and polarity 0 latches only falling edges. A latched event holds until it is cleared.
- R7: With the both-edges bit set, an edge-mode pin latches rising and falling edges whatever its polarity bit says.
- R8: Writing 1 to bit n of the clear register (index 8) clears pin n's latched event, and 0 bits have no effect. An edge detected in the same cycle as the clear wins, and the event stays set.
- R9: Masked status (index 7) equals raw status (index 6) ANDed with the enable register (index 5). Only masked status reaches `irq_o`.
- R10: `irq_o[i]` equals masked bit i for i = 0, 1, 2. `irq_o[3]` is the OR of masked bits 3 to 7.
- R11: Banks 1 and 2 have no interrupt registers. Indices 2 to 8 read 0 there, and writes to them change nothing.
- R12: An edge event raises `irq_o` on the third rising clock after the pin change. A level condition raises it on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe; the write is taken on the rising edge |
| bus_addr | input | 12 | Region, bank and mask/register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| gpio_in | input | 24 | Pad input values |
| gpio_out | output | 24 | Pad output values |
| gpio_oe | output | 24 | Pad output enables |
| alt_sel | output | 24 | Alternate-function select per pin |
| irq_o | output | 4 | Interrupt lines to the parent controller |

## Verification
The assertions assume that the bus is quiet during reset and that `bus_addr` and `bus_wdata` are stable around each rising edge. They also assume that every pin event a check relies on is held for at least three clocks, so the synchroniser and edge detector see each level. The bench drives all bus and pad inputs on falling clock edges and holds each pad value for at least three cycles. The one exception is the deliberate collision of an edge with a clear, which is timed against the known synchroniser depth.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam logic [1:0] REGION_DATA = 2'd0;
  localparam logic [1:0] REGION_CTRL = 2'd1;

  typedef enum logic [3:0] {
    IDX_DIR  = 4'd0,
    IDX_ALT  = 4'd1,
    IDX_LVL  = 4'd2,
    IDX_DUAL = 4'd3,
    IDX_POL  = 4'd4,
    IDX_EN   = 4'd5,
    IDX_RAW  = 4'd6,
    IDX_MSK  = 4'd7,
    IDX_CLR  = 4'd8
  } ctrl_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic         wr_dir,
  input  logic         wr_alt,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dout,
  output logic [W-1:0] dir,
  output logic [W-1:0] alt,
  output logic [W-1:0] view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
      alt  <= '0;
    end else begin
      if (wr_data) dout <= (dout & ~wr_mask) | (wdata & wr_mask);
      if (wr_dir)  dir  <= wdata;
      if (wr_alt)  alt  <= wdata;
    end
  end

  assign view = (dir & dout) | (~dir & pin_sync);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W     = 8,
  parameter int NSOLO = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   pin_sync,
  input  logic           wr_lvl,
  input  logic           wr_dual,
  input  logic           wr_pol,
  input  logic           wr_en,
  input  logic [W-1:0]   wdata,
  input  logic [W-1:0]   clr,
  output logic [W-1:0]   lvl,
  output logic [W-1:0]   dual,
  output logic [W-1:0]   pol,
  output logic [W-1:0]   en,
  output logic [W-1:0]   lat,
  output logic [W-1:0]   raw,
  output logic [W-1:0]   masked,
  output logic [NSOLO:0] irq
);
  logic [W-1:0] prev, rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= '0;
      dual <= '0;
      pol  <= '0;
      en   <= '0;
      prev <= '0;
      lat  <= '0;
    end else begin
      if (wr_lvl)  lvl  <= wdata;
      if (wr_dual) dual <= wdata;
      if (wr_pol)  pol  <= wdata;
      if (wr_en)   en   <= wdata;
      prev <= pin_sync;
      lat  <= (lat & ~clr) | hit;
    end
  end

  assign rise   = pin_sync & ~prev;
  assign fall   = ~pin_sync & prev;
  assign hit    = ~lvl & ((dual & (rise | fall)) | (~dual & pol & rise) | (~dual & ~pol & fall));
  assign raw    = (lvl & ~(pin_sync ^ pol)) | (~lvl & lat);
  assign masked = raw & en;

  for (genvar i = 0; i < NSOLO; i++) begin : g_solo
    assign irq[i] = masked[i];
  end
  assign irq[NSOLO] = |masked[W-1:NSOLO];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NBANKS = 3,
  parameter int BW     = 8,
  parameter int NSOLO  = 3,
  parameter int AW     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [BW-1:0]        bus_wdata,
  output logic [BW-1:0]        bus_rdata,
  input  logic [NBANKS*BW-1:0] gpio_in,
  output logic [NBANKS*BW-1:0] gpio_out,
  output logic [NBANKS*BW-1:0] gpio_oe,
  output logic [NBANKS*BW-1:0] alt_sel,
  output logic [NSOLO:0]       irq_o
);
  localparam int NPINS = NBANKS * BW;

  logic [1:0]      region;
  logic [1:0]      bank;
  ctrl_idx_e       idx;
  logic            ctrl_wr;
  logic [NPINS-1:0] pin_sync;

  assign region  = bus_addr[AW-1:AW-2];
  assign bank    = bus_addr[AW-3:AW-4];
  assign idx     = ctrl_idx_e'(bus_addr[3:0]);
  assign ctrl_wr = bus_we && region == REGION_CTRL;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_sync)
  );

  logic [BW-1:0] dout_a [NBANKS];
  logic [BW-1:0] dir_a  [NBANKS];
  logic [BW-1:0] alt_a  [NBANKS];
  logic [BW-1:0] view_a [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = bank == 2'(b);
    gpio_bank #(.W(BW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_data(bus_we && region == REGION_DATA && hit_bank),
      .wr_mask(bus_addr[BW-1:0]),
      .wr_dir(ctrl_wr && hit_bank && idx == IDX_DIR),
      .wr_alt(ctrl_wr && hit_bank && idx == IDX_ALT),
      .wdata(bus_wdata),
      .pin_sync(pin_sync[b*BW +: BW]),
      .dout(dout_a[b]), .dir(dir_a[b]), .alt(alt_a[b]), .view(view_a[b])
    );
    assign gpio_out[b*BW +: BW] = dout_a[b];
    assign gpio_oe[b*BW +: BW]  = dir_a[b] & ~alt_a[b];
    assign alt_sel[b*BW +: BW]  = alt_a[b];
  end

  logic          irq_wr;
  logic [BW-1:0] clr_vec;
  logic [BW-1:0] irq_lvl, irq_dual, irq_pol, irq_en, edge_lat, irq_raw, irq_msk;

  assign irq_wr  = ctrl_wr && bank == 2'd0;
  assign clr_vec = (irq_wr && idx == IDX_CLR) ? bus_wdata : '0;

  gpio_irq_unit #(.W(BW), .NSOLO(NSOLO)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .pin_sync(pin_sync[BW-1:0]),
    .wr_lvl(irq_wr && idx == IDX_LVL),
    .wr_dual(irq_wr && idx == IDX_DUAL),
    .wr_pol(irq_wr && idx == IDX_POL),
    .wr_en(irq_wr && idx == IDX_EN),
    .wdata(bus_wdata), .clr(clr_vec),
    .lvl(irq_lvl), .dual(irq_dual), .pol(irq_pol), .en(irq_en),
    .lat(edge_lat), .raw(irq_raw), .masked(irq_msk), .irq(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank == 2'(b)) begin
        if (region == REGION_DATA) begin
          bus_rdata = view_a[b] & bus_addr[BW-1:0];
        end else if (region == REGION_CTRL) begin
          if (idx == IDX_DIR) bus_rdata = dir_a[b];
          if (idx == IDX_ALT) bus_rdata = alt_a[b];
          if (b == 0) begin
            case (idx)
              IDX_LVL:  bus_rdata = irq_lvl;
              IDX_DUAL: bus_rdata = irq_dual;
              IDX_POL:  bus_rdata = irq_pol;
              IDX_EN:   bus_rdata = irq_en;
              IDX_RAW:  bus_rdata = irq_raw;
              IDX_MSK:  bus_rdata = irq_msk;
              default:  ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NPINS = 24,
  parameter int BW    = 8,
  parameter int NSOLO = 3,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] gpio_out,
  input logic [NPINS-1:0] gpio_oe,
  input logic [NPINS-1:0] alt_sel,
  input logic [NSOLO:0]   irq_o,
  input logic [BW-1:0]    en_q,
  input logic [BW-1:0]    lat_q,
  input logic [BW-1:0]    clr_q
);
  // R3: a pin handed to its alternate function never has its output enabled
  assert_oe_yields_alt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_oe & alt_sel) == '0);

  // R2: a masked write to bank 0 leaves unselected output bits untouched
  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:AW-4] == 4'b0000) |=>
    ((gpio_out[BW-1:0] ^ $past(gpio_out[BW-1:0])) & ~$past(bus_addr[BW-1:0])) == '0);

  // R9: a dedicated line is only raised for an enabled pin
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[NSOLO-1:0] & ~en_q[NSOLO-1:0]) == '0);

  // R10: the shared line needs at least one enabled upper pin
  assert_shared_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[NSOLO] |-> (|en_q[BW-1:NSOLO]));

  // R8: a latched edge survives any cycle in which its clear bit is 0
  assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lat_q) & ~$past(clr_q) & ~lat_q) == '0);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS), .BW(BW), .NSOLO(NSOLO), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alt_sel(alt_sel), .irq_o(irq_o),
  .en_q(irq_en), .lat_q(edge_lat), .clr_q(clr_vec)
);

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] gpio_in = '0;
  logic [23:0] gpio_out, gpio_oe, alt_sel;
  logic [3:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alt_sel(alt_sel), .irq_o(irq_o)
  );

  localparam logic [3:0] I_DIR = 4'd0, I_ALT = 4'd1, I_LVL = 4'd2, I_DUAL = 4'd3,
                         I_POL = 4'd4, I_EN = 4'd5, I_RAW = 4'd6, I_MSK = 4'd7, I_CLR = 4'd8;

  function automatic logic [11:0] ca(input logic [1:0] b, input logic [3:0] i);
    return {2'b01, b, 4'h0, i};
  endfunction
  function automatic logic [11:0] da(input logic [1:0] b, input logic [7:0] m);
    return {2'b00, b, m};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 gpio_out", gpio_out, 0);
    chk("R1 gpio_oe", gpio_oe, 0);
    chk("R1 alt_sel", alt_sel, 0);
    chk("R1 irq_o", irq_o, 0);
    rd(ca(0, I_DIR), v); chk("R1 dir", v, 0);
    rd(ca(0, I_EN), v);  chk("R1 enable", v, 0);
    rd(ca(0, I_LVL), v); chk("R1 level-mode", v, 0);
  endtask

  task automatic t_data;
    logic [7:0] v;
    wr(ca(1, I_DIR), 8'hFF);
    wr(da(1, 8'hF0), 8'hAA);
    chk("R2 upper nibble write", gpio_out[15:8], 8'hA0);
    wr(da(1, 8'h0F), 8'h55);
    chk("R2 lower nibble write", gpio_out[15:8], 8'hA5);
    rd(da(1, 8'hFF), v); chk("R4 output readback", v, 8'hA5);
    chk("R3 oe all outputs", gpio_oe[15:8], 8'hFF);
    wr(ca(1, I_ALT), 8'h0F);
    chk("R3 oe withdrawn for alt", gpio_oe[15:8], 8'hF0);
    chk("R3 alt_sel mapping", alt_sel, 24'h000F00);
    gpio_in[23:16] = 8'h3C;
    step(3);
    rd(da(2, 8'hF0), v); chk("R4 input readback masked", v, 8'h30);
  endtask

  task automatic t_level;
    logic [7:0] v;
    wr(ca(0, I_LVL), 8'h01);
    wr(ca(0, I_POL), 8'h01);
    wr(ca(0, I_EN), 8'h01);
    gpio_in[0] = 1'b1;
    step(1); chk("R12 level not yet", irq_o[0], 0);
    step(1); chk("R12 level on second edge", irq_o[0], 1);
    wr(ca(0, I_CLR), 8'h01);
    rd(ca(0, I_RAW), v); chk("R5 clear ignored in level mode", v[0], 1);
    gpio_in[0] = 1'b0;
    step(3); chk("R5 high level released", irq_o[0], 0);
    wr(ca(0, I_POL), 8'h00);
    chk("R5 low level active", irq_o[0], 1);
    wr(ca(0, I_LVL), 8'h00);
    wr(ca(0, I_EN), 8'h00);
    wr(ca(0, I_CLR), 8'hFF);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    wr(ca(0, I_POL), 8'h02);
    wr(ca(0, I_EN), 8'h02);
    gpio_in[1] = 1'b1;
    step(2); chk("R12 edge not before third clock", irq_o[1], 0);
    step(1); chk("R12 rising edge latched", irq_o[1], 1);
    step(4); chk("R6 event held", irq_o[1], 1);
    wr(ca(0, I_CLR), 8'h02);
    chk("R6 event cleared", irq_o[1], 0);
    gpio_in[1] = 1'b0;
    step(3);
    rd(ca(0, I_RAW), v); chk("R6 falling ignored in rising mode", v[1], 0);
    wr(ca(0, I_POL), 8'h00);
    wr(ca(0, I_EN), 8'h00);
  endtask

  task automatic t_dual;
    wr(ca(0, I_DUAL), 8'h04);
    wr(ca(0, I_EN), 8'h04);
    gpio_in[2] = 1'b1;
    step(3); chk("R7 rising caught despite falling polarity", irq_o[2], 1);
    wr(ca(0, I_CLR), 8'h04);
    chk("R7 cleared", irq_o[2], 0);
    gpio_in[2] = 1'b0;
    step(3); chk("R7 falling caught", irq_o[2], 1);
    wr(ca(0, I_CLR), 8'h04);
    wr(ca(0, I_DUAL), 8'h00);
    wr(ca(0, I_EN), 8'h00);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(ca(0, I_EN), 8'h18);
    gpio_in[4:3] = 2'b11;
    step(3);
    gpio_in[4:3] = 2'b00;
    step(3);
    rd(ca(0, I_RAW), v); chk("R8 both falls latched", v, 8'h18);
    chk("R10 shared line set", irq_o[3], 1);
    wr(ca(0, I_CLR), 8'h08);
    rd(ca(0, I_RAW), v); chk("R8 only bit 3 cleared", v, 8'h10);
    chk("R10 shared line still set", irq_o[3], 1);
    wr(ca(0, I_CLR), 8'h00);
    rd(ca(0, I_RAW), v); chk("R8 zero bits no effect", v, 8'h10);
    wr(ca(0, I_CLR), 8'h10);
    chk("R10 shared line released", irq_o[3], 0);
    gpio_in[4] = 1'b1;
    step(3);
    @(negedge clk);
    gpio_in[4] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(ca(0, I_CLR), 8'h10);
    rd(ca(0, I_RAW), v); chk("R8 edge wins over clear", v[4], 1);
    wr(ca(0, I_CLR), 8'hFF);
    wr(ca(0, I_EN), 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    gpio_in[5] = 1'b1;
    step(3);
    gpio_in[5] = 1'b0;
    step(3);
    rd(ca(0, I_RAW), v); chk("R9 raw shows event", v, 8'h20);
    rd(ca(0, I_MSK), v); chk("R9 masked hidden", v, 8'h00);
    chk("R9 no line while masked", irq_o, 4'b0000);
    wr(ca(0, I_EN), 8'h20);
    rd(ca(0, I_MSK), v); chk("R9 masked visible", v, 8'h20);
    chk("R10 pin 5 on shared line only", irq_o, 4'b1000);
    wr(ca(0, I_CLR), 8'hFF);
    wr(ca(0, I_EN), 8'h00);
  endtask

  task automatic t_upper_banks;
    logic [7:0] v;
    wr(ca(1, I_LVL), 8'hFF);
    wr(ca(2, I_EN), 8'hFF);
    rd(ca(1, I_LVL), v); chk("R11 bank1 level-mode absent", v, 0);
    rd(ca(2, I_EN), v);  chk("R11 bank2 enable absent", v, 0);
    rd(ca(0, I_LVL), v); chk("R11 bank0 level-mode untouched", v, 0);
    rd(ca(0, I_EN), v);  chk("R11 bank0 enable untouched", v, 0);
    chk("R11 no interrupt", irq_o, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_data;
    t_level;
    t_edge;
    t_dual;
    t_clear;
    t_mask;
    t_upper_banks;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule